// File: doc/BRIEF.md
# Pipeline Hazard and Operand Bypass Control

This unit is the interlock and bypass controller of a five-stage in-order pipeline: fetch, decode, execute, memory, writeback. Each cycle it looks at the source registers of the instruction in decode and at the destination registers and flags of the instructions in execute and memory. From these it produces the operand bypass selects for the execute stage and for the branch comparator, which sits in decode. It also produces the stall controls.

The execute-stage selects are computed one cycle early, while the consumer is still in decode, and are registered. When the consumer reaches execute, its producers have each moved one stage further on, and the registered select points at the stage where each producer now sits. A stall freezes the PC and the fetch/decode register and turns the next execute-stage entry into a bubble. Branches have a delay slot, so the unit never cancels an instruction that has already been fetched. The register file writes before it reads, so a writeback result needs no bypass into decode.

A source field of 0 means "no register read". Register 0 is never a bypass source and never causes a stall.

Top module: `hazard_fwd_unit`

## Requirements
- R1: On the first cycle after reset, both execute selects read 0, and with every write flag clear the unit asserts no stall: `pc_we`=1, `ifid_we`=1, `idex_bubble`=0.
- R2: The execute select is 2 bits: 0 means register file, 1 means the result held after execute, 2 means the value held after memory. The value shown in a cycle belongs to the instruction that was in decode at the previous clock edge. It is 1 if that operand matched a writing instruction then in execute, and 2 if it matched a writing instruction then in memory.
- R3: When the instruction in execute and the instruction in memory both write the operand's register, the younger one wins and the select is 1.
- R4: A destination of 0 never produces a bypass or a stall, even for a load or a branch.
- R5: If a decode source matches the destination of a load in execute, the unit stalls for that cycle: `pc_we`=0, `ifid_we`=0, `idex_bubble`=1. The selects of the next cycle are both 0, whatever other matches exist.
- R6: A non-branch that was held behind a load proceeds without a stall once the load is in memory, and its next select for that operand is 2.
- R7: A branch in decode whose source matches an ALU (non-load) writer in execute stalls for one cycle. When that writer is in memory, the branch does not stall and the matching `id_fwd_*` output is 1.
- R8: A branch in decode whose source matches a load stalls while the load is in execute and again while it is in memory. `id_fwd_*` stays 0 throughout. Once the load has left memory, there is no stall.
- R9: A non-branch whose source matches an ALU writer in execute does not stall, and its next select is 1.
- R10: A stage whose write flag is clear never causes a bypass or a stall, even if its destination matches and its load flag is set.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| id_src_a | input | REG_W | First source register of the decode instruction (0 = none) |
| id_src_b | input | REG_W | Second source register of the decode instruction (0 = none) |
| id_branch | input | 1 | Decode instruction is a conditional branch |
| ex_dst | input | REG_W | Destination register of the execute instruction |
| ex_wr | input | 1 | Execute instruction writes a register |
| ex_load | input | 1 | Execute instruction is a load |
| mem_dst | input | REG_W | Destination register of the memory-stage instruction |
| mem_wr | input | 1 | Memory-stage instruction writes a register |
| mem_load | input | 1 | Memory-stage instruction is a load |
| ex_fwd_a | output | 2 | Execute-stage select for operand A (0 RF, 1 post-execute, 2 post-memory) |
| ex_fwd_b | output | 2 | Execute-stage select for operand B |
| id_fwd_a | output | 1 | Branch comparator operand A takes the post-execute result |
| id_fwd_b | output | 1 | Branch comparator operand B takes the post-execute result |
| pc_we | output | 1 | PC update enable (0 = hold) |
| ifid_we | output | 1 | Fetch/decode register enable (0 = hold) |
| idex_bubble | output | 1 | Clear control bits entering execute |

## Verification
A stall and a bypass can fall in the same cycle. A decode instruction can be stalled by one operand while its other operand matches an older writer. A branch can also receive a decode-stage bypass on one source while its other source is blocked by a load in execute. The bench sets up the first case by giving operand B a memory-stage ALU match while operand A hits a load in execute. It then requires the stall outputs to assert and both registered selects of the next cycle to read 0. It also drives branches through the one-cycle and two-cycle stall sequences. For each of those cycles it checks the stall outputs, the branch bypass bits and the registered selects.

// File: rtl/hazard_pkg.sv
package hazard_pkg;

    // Execute-stage operand source
    typedef enum logic [1:0] {
        FWD_RF  = 2'd0,
        FWD_MEM = 2'd1,
        FWD_WB  = 2'd2
    } fwd_sel_e;

    // Pipeline front-end control produced by the interlock
    typedef struct packed {
        logic pc_we;
        logic ifid_we;
        logic idex_bubble;
    } hz_ctl_t;

    function automatic hz_ctl_t ctl_from_stall(input logic stall);
        hz_ctl_t c;
        c.pc_we       = ~stall;
        c.ifid_we     = ~stall;
        c.idex_bubble = stall;
        return c;
    endfunction

endpackage

// File: rtl/hz_match.sv
module hz_match #(
    parameter int REG_W = 5
) (
    input  logic [REG_W-1:0] src,
    input  logic [REG_W-1:0] dst,
    input  logic             wr,
    output logic             hit
);
    // A writer targets this source; register 0 is never a real producer
    assign hit = wr && (dst != '0) && (dst == src);
endmodule

// File: rtl/hz_stall_detect.sv
module hz_stall_detect
    import hazard_pkg::*;
#(
    parameter int NSRC = 2
) (
    input  logic [NSRC-1:0] ex_hit,
    input  logic [NSRC-1:0] mem_hit,
    input  logic            id_branch,
    input  logic            ex_load,
    input  logic            mem_load,
    output logic            stall,
    output hz_ctl_t         ctl
);
    logic load_use;
    logic br_on_ex;
    logic br_on_mem_load;

    always_comb begin
        load_use       = ex_load && (|ex_hit);
        br_on_ex       = id_branch && (|ex_hit);
        br_on_mem_load = id_branch && mem_load && (|mem_hit);
        stall          = load_use || br_on_ex || br_on_mem_load;
        ctl            = ctl_from_stall(stall);
    end
endmodule

// File: rtl/hz_ex_fwd_pre.sv
module hz_ex_fwd_pre
    import hazard_pkg::*;
#(
    parameter int NSRC = 2
) (
    input  logic                 clk,
    input  logic                 rst,
    input  logic [NSRC-1:0]      ex_hit,
    input  logic [NSRC-1:0]      mem_hit,
    input  logic                 stall,
    output fwd_sel_e [NSRC-1:0]  sel_q
);
    // Producers move one stage on at the edge: EX->MEM, MEM->WB
    for (genvar i = 0; i < NSRC; i++) begin : g_op
        always_ff @(posedge clk) begin
            if (rst) begin
                sel_q[i] <= FWD_RF;
            end else if (stall) begin
                sel_q[i] <= FWD_RF;
            end else if (ex_hit[i]) begin
                sel_q[i] <= FWD_MEM;
            end else if (mem_hit[i]) begin
                sel_q[i] <= FWD_WB;
            end else begin
                sel_q[i] <= FWD_RF;
            end
        end
    end
endmodule

// File: rtl/hz_id_fwd.sv
module hz_id_fwd #(
    parameter int NSRC = 2
) (
    input  logic [NSRC-1:0] mem_hit,
    input  logic            id_branch,
    input  logic            mem_load,
    output logic [NSRC-1:0] id_sel
);
    // Only an ALU result already past execute can feed the comparator
    for (genvar i = 0; i < NSRC; i++) begin : g_op
        assign id_sel[i] = id_branch && !mem_load && mem_hit[i];
    end
endmodule

// File: rtl/hazard_fwd_unit.sv
module hazard_fwd_unit
    import hazard_pkg::*;
#(
    parameter int REG_W = 5
) (
    input  logic             clk,
    input  logic             rst,
    input  logic [REG_W-1:0] id_src_a,
    input  logic [REG_W-1:0] id_src_b,
    input  logic             id_branch,
    input  logic [REG_W-1:0] ex_dst,
    input  logic             ex_wr,
    input  logic             ex_load,
    input  logic [REG_W-1:0] mem_dst,
    input  logic             mem_wr,
    input  logic             mem_load,
    output logic [1:0]       ex_fwd_a,
    output logic [1:0]       ex_fwd_b,
    output logic             id_fwd_a,
    output logic             id_fwd_b,
    output logic             pc_we,
    output logic             ifid_we,
    output logic             idex_bubble
);
    localparam int NSRC = 2;

    logic [NSRC-1:0][REG_W-1:0] srcs;
    logic [NSRC-1:0]            ex_hit;
    logic [NSRC-1:0]            mem_hit;
    logic [NSRC-1:0]            id_sel;
    fwd_sel_e [NSRC-1:0]        sel_q;
    logic                       stall;
    hz_ctl_t                    ctl;

    assign srcs = {id_src_b, id_src_a};

    for (genvar i = 0; i < NSRC; i++) begin : g_src
        hz_match #(.REG_W(REG_W)) u_ex_m (
            .src(srcs[i]), .dst(ex_dst), .wr(ex_wr), .hit(ex_hit[i])
        );
        hz_match #(.REG_W(REG_W)) u_mem_m (
            .src(srcs[i]), .dst(mem_dst), .wr(mem_wr), .hit(mem_hit[i])
        );
    end

    hz_stall_detect #(.NSRC(NSRC)) u_stall (
        .ex_hit(ex_hit), .mem_hit(mem_hit), .id_branch(id_branch),
        .ex_load(ex_load), .mem_load(mem_load),
        .stall(stall), .ctl(ctl)
    );

    hz_ex_fwd_pre #(.NSRC(NSRC)) u_pre (
        .clk(clk), .rst(rst), .ex_hit(ex_hit), .mem_hit(mem_hit),
        .stall(stall), .sel_q(sel_q)
    );

    hz_id_fwd #(.NSRC(NSRC)) u_idf (
        .mem_hit(mem_hit), .id_branch(id_branch), .mem_load(mem_load),
        .id_sel(id_sel)
    );

    assign ex_fwd_a    = sel_q[0];
    assign ex_fwd_b    = sel_q[1];
    assign id_fwd_a    = id_sel[0];
    assign id_fwd_b    = id_sel[1];
    assign pc_we       = ctl.pc_we;
    assign ifid_we     = ctl.ifid_we;
    assign idex_bubble = ctl.idex_bubble;
endmodule

// File: rtl/hazard_fwd_unit_chk.sv
module hazard_fwd_unit_chk #(
    parameter int REG_W = 5
) (
    input logic             clk,
    input logic             rst,
    input logic [REG_W-1:0] id_src_a,
    input logic [REG_W-1:0] id_src_b,
    input logic             id_branch,
    input logic [REG_W-1:0] ex_dst,
    input logic             ex_wr,
    input logic             ex_load,
    input logic [REG_W-1:0] mem_dst,
    input logic             mem_wr,
    input logic             mem_load,
    input logic [1:0]       ex_fwd_a,
    input logic [1:0]       ex_fwd_b,
    input logic             id_fwd_a,
    input logic             id_fwd_b,
    input logic             pc_we,
    input logic             ifid_we,
    input logic             idex_bubble
);
    a_r5_front_end_consistent: assert property (@(posedge clk) disable iff (rst)
        (pc_we == ifid_we) && (idex_bubble != pc_we));

    a_r5_bubble_clears_sel: assert property (@(posedge clk) disable iff (rst)
        idex_bubble |=> (ex_fwd_a == 2'd0) && (ex_fwd_b == 2'd0));

    a_r2_sel_legal: assert property (@(posedge clk) disable iff (rst)
        (ex_fwd_a != 2'd3) && (ex_fwd_b != 2'd3));

    a_r4_mem_sel_has_producer: assert property (@(posedge clk) disable iff (rst)
        (ex_fwd_a == 2'd1) |-> ($past(ex_wr) && ($past(ex_dst) != '0)
                                && ($past(ex_dst) == $past(id_src_a))));

    a_r7_id_fwd_alu_only: assert property (@(posedge clk) disable iff (rst)
        (id_fwd_a || id_fwd_b) |-> (id_branch && mem_wr && !mem_load && (mem_dst != '0)));

    a_r8_branch_waits_mem_load: assert property (@(posedge clk) disable iff (rst)
        (id_branch && mem_wr && mem_load && (mem_dst != '0) && (mem_dst == id_src_a))
        |-> !pc_we);
endmodule

bind hazard_fwd_unit hazard_fwd_unit_chk #(.REG_W(REG_W)) u_chk (.*);

// File: tb/hazard_fwd_unit_tb.sv
module hazard_fwd_unit_tb;
    localparam int CLK_P = 10;
    localparam int RW    = 5;

    logic          clk = 1'b0;
    logic          rst;
    logic [RW-1:0] id_src_a, id_src_b, ex_dst, mem_dst;
    logic          id_branch, ex_wr, ex_load, mem_wr, mem_load;
    logic [1:0]    ex_fwd_a, ex_fwd_b;
    logic          id_fwd_a, id_fwd_b, pc_we, ifid_we, idex_bubble;

    int total = 0;
    int bad   = 0;
    bit done  = 1'b0;

    always #(CLK_P/2) clk = ~clk;

    hazard_fwd_unit #(.REG_W(RW)) u_dut (
        .clk(clk), .rst(rst), .id_src_a(id_src_a), .id_src_b(id_src_b),
        .id_branch(id_branch), .ex_dst(ex_dst), .ex_wr(ex_wr), .ex_load(ex_load),
        .mem_dst(mem_dst), .mem_wr(mem_wr), .mem_load(mem_load),
        .ex_fwd_a(ex_fwd_a), .ex_fwd_b(ex_fwd_b), .id_fwd_a(id_fwd_a),
        .id_fwd_b(id_fwd_b), .pc_we(pc_we), .ifid_we(ifid_we),
        .idex_bubble(idex_bubble)
    );

    task automatic chk(input string tag, input int act, input int exp);
        total++;
        if (act != exp) begin
            bad++;
            $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
        end
    endtask

    // Drive one cycle of stage contents just after a falling edge
    task automatic drive(input int a, input int b, input bit br,
                         input int exd, input bit exw, input bit exl,
                         input int md, input bit mw, input bit ml);
        @(negedge clk);
        id_src_a = RW'(a); id_src_b = RW'(b); id_branch = br;
        ex_dst = RW'(exd); ex_wr = exw; ex_load = exl;
        mem_dst = RW'(md); mem_wr = mw; mem_load = ml;
        #1;
    endtask

    task automatic chk_stall(input string tag, input bit exp_stall);
        chk({tag, " pc_we"}, int'(pc_we), int'(!exp_stall));
        chk({tag, " ifid_we"}, int'(ifid_we), int'(!exp_stall));
        chk({tag, " idex_bubble"}, int'(idex_bubble), int'(exp_stall));
    endtask

    // Registered selects, sampled just after the next rising edge
    task automatic chk_sel(input string tag, input int ea, input int eb);
        @(posedge clk); #1;
        chk({tag, " ex_fwd_a"}, int'(ex_fwd_a), ea);
        chk({tag, " ex_fwd_b"}, int'(ex_fwd_b), eb);
    endtask

    task automatic t_reset();
        rst = 1'b1;
        drive(0, 0, 0, 0, 0, 0, 0, 0, 0);
        @(posedge clk); @(posedge clk); #1;
        rst = 1'b0;
        chk("R1 reset ex_fwd_a", int'(ex_fwd_a), 0);
        chk("R1 reset ex_fwd_b", int'(ex_fwd_b), 0);
        chk_stall("R1 idle", 1'b0);
    endtask

    task automatic t_ex_fwd();
        // R2: a matches EX writer -> 1, b matches MEM writer -> 2
        drive(3, 4, 0, 3, 1, 0, 4, 1, 0);
        chk_stall("R2 no stall", 1'b0);
        chk_sel("R2 basic", 1, 2);
        // R3: both stages write r6 -> younger (1)
        drive(6, 7, 0, 6, 1, 0, 6, 1, 0);
        chk_sel("R3 priority", 1, 0);
        // R2: MEM load match -> 2
        drive(7, 6, 0, 9, 1, 0, 7, 1, 1);
        chk_sel("R2 mem load", 2, 0);
    endtask

    task automatic t_zero_reg();
        // R4: load and ALU writers to r0 with r0 sources
        drive(0, 0, 1, 0, 1, 1, 0, 1, 1);
        chk_stall("R4 r0 load", 1'b0);
        chk("R4 id_fwd_a", int'(id_fwd_a), 0);
        chk_sel("R4 r0", 0, 0);
        drive(0, 0, 1, 0, 1, 0, 0, 1, 0);
        chk("R4 id_fwd_b", int'(id_fwd_b), 0);
        chk_sel("R4 r0 alu", 0, 0);
    endtask

    task automatic t_load_use();
        // R5: a hits EX load r5, b hits MEM ALU r9 -> stall, bubble selects
        drive(5, 9, 0, 5, 1, 1, 9, 1, 0);
        chk_stall("R5 load-use", 1'b1);
        chk_sel("R5 bubble", 0, 0);
        // R6: load now in MEM, EX empty
        drive(5, 9, 0, 0, 0, 0, 5, 1, 1);
        chk_stall("R6 resume", 1'b0);
        chk_sel("R6 from wb", 2, 0);
    endtask

    task automatic t_branch_alu();
        // R7: branch b on ALU r11 in EX
        drive(1, 11, 1, 11, 1, 0, 0, 0, 0);
        chk_stall("R7 br on ex", 1'b1);
        chk("R7 id_fwd_b stalled", int'(id_fwd_b), 0);
        chk_sel("R7 bubble", 0, 0);
        drive(1, 11, 1, 0, 0, 0, 11, 1, 0);
        chk_stall("R7 br on mem", 1'b0);
        chk("R7 id_fwd_b", int'(id_fwd_b), 1);
        chk("R7 id_fwd_a", int'(id_fwd_a), 0);
        chk_sel("R7 after", 0, 2);
    endtask

    task automatic t_branch_load();
        // R8: branch a on load r12: EX, MEM, then gone
        drive(12, 2, 1, 12, 1, 1, 0, 0, 0);
        chk_stall("R8 load in ex", 1'b1);
        chk_sel("R8 c1", 0, 0);
        drive(12, 2, 1, 0, 0, 0, 12, 1, 1);
        chk_stall("R8 load in mem", 1'b1);
        chk("R8 id_fwd_a", int'(id_fwd_a), 0);
        chk_sel("R8 c2", 0, 0);
        drive(12, 2, 1, 0, 0, 0, 0, 0, 0);
        chk_stall("R8 load in wb", 1'b0);
        chk("R8 id_fwd_a wb", int'(id_fwd_a), 0);
        chk_sel("R8 c3", 0, 0);
    endtask

    task automatic t_nonbranch_alu();
        // R9: ALU in EX feeds a non-branch without stall
        drive(13, 13, 0, 13, 1, 0, 0, 0, 0);
        chk_stall("R9 no stall", 1'b0);
        chk_sel("R9 sel", 1, 1);
    endtask

    task automatic t_no_write();
        // R10: matches with write flags clear
        drive(14, 15, 1, 14, 0, 1, 15, 0, 1);
        chk_stall("R10 no wr", 1'b0);
        chk("R10 id_fwd_b", int'(id_fwd_b), 0);
        chk_sel("R10 sel", 0, 0);
        drive(14, 15, 1, 0, 0, 0, 15, 0, 0);
        chk("R10 id_fwd_b alu", int'(id_fwd_b), 0);
        chk_sel("R10 sel2", 0, 0);
    endtask

    initial begin
        t_reset();
        t_ex_fwd();
        t_zero_reg();
        t_load_use();
        t_branch_alu();
        t_branch_load();
        t_nonbranch_alu();
        t_no_write();
        done = 1'b1;
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        #(CLK_P * 5000);
        if (!done) begin
            total++;
            bad++;
            $display("FAIL watchdog R1 actual=running expected=finished");
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end
endmodule